// File: doc/BRIEF.md
# Two-Thread Branch Direction and Target Predictor

This block predicts, for the fetch stage of an in-order processor that runs two hardware threads, whether a branch at a given fetch address will be taken and where it goes. A lookup presents a thread number, a fetch address and a kind flag that separates conditional branches from unconditional jumps. In the same cycle the block returns a direction, a flag saying whether a target is known, the target itself, and the penalty class the front end should expect. When the branch resolves, an update presents the real outcome and target. One cycle later the block reports how that branch was classified: correctly predicted, target miss or direction mispredict.

Direction comes from a table of 2-bit saturating counters. Both threads share this table. Each thread indexes it with its own global history register XORed with fetch-address bits. A set-associative target buffer, shared by both threads and tagged without the thread number, holds targets. For each branch it also records whether the branch has been seen taken and whether it has been seen not-taken. A branch seen only one way is predicted from that mark and does not touch the counter table. Unconditional jumps go around the direction machinery entirely.

Top module: `bp_predictor`

## Requirements
- R1: After reset, every lookup of a conditional branch predicts not-taken, reports no target (target-valid low) and penalty class 0. Both history registers read zero and every counter reads weakly not-taken (binary 01).
- R2: For a conditional branch with no biased target-buffer entry, the direction is the upper bit of the counter indexed by the thread's history XOR fetch-address bits [HIST_W+1:2]. A counter trained by a qualifying update moves one step toward the outcome and saturates at 00 and 11.
- R3: An update of a conditional branch shifts the owning thread's history left by one and puts the outcome (1 = taken) in bit 0. The other thread's history does not change.
- R4: A lookup with the kind flag set (1 = unconditional jump) always predicts taken. An update with the kind flag set changes neither the history registers nor the counter table, and it is treated as taken whatever up_taken says.
- R5: A conditional branch that hits a target-buffer entry with exactly one bias mark set is predicted from that mark: seen-taken alone gives taken, seen-not-taken alone gives not-taken.
- R6: A conditional update trains the counter table only if it hits a target-buffer entry whose two bias marks were both set before that update. A taken hit sets the seen-taken mark and a not-taken hit sets the seen-not-taken mark.
- R7: The target buffer has SETS sets of WAYS ways. The set is fetch-address bits [log2(SETS)+1:2] and the tag is every bit above them, with no thread number. A hit raises target-valid and returns the stored target. A taken update that hits replaces that target.
- R8: An entry is allocated only by a taken update (or jump) that misses, with only seen-taken set. The lowest-numbered invalid way is used first; once the set is full, the way chosen by a per-set binary-tree pseudo-LRU is used. Every hit update and every allocation makes its way most recently used.
- R9: The lookup penalty class is 1 (target-miss class, 7 cycles) when the prediction is taken and target-valid is low. Otherwise it is 0.
- R10: One cycle after each update, rs_vld is high and rs_cls gives the class: 2 (mispredict, 13 cycles) when the prediction made from the tables as they stood before the update differs from the outcome; 1 when the direction was right, the branch was taken and there was no target-buffer hit; 0 otherwise. rs_vld is low in the cycle after a cycle with no update.
- R11: An update takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the old tables, and a lookup in the next cycle sees the new ones.
- R12: Both threads read and train the same counter table and the same target buffer. An entry installed by one thread hits for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_tid | input | TID_W | Thread of the lookup |
| lk_pc | input | PC_W | Fetch address of the lookup |
| lk_kind | input | 1 | 1 = unconditional jump, 0 = conditional |
| lk_taken | output | 1 | Predicted direction |
| lk_tgt_vld | output | 1 | Target buffer hit |
| lk_tgt | output | PC_W | Predicted target |
| lk_pen | output | 2 | Penalty class: 0 none, 1 target miss |
| up_vld | input | 1 | Update present |
| up_tid | input | TID_W | Thread of the resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_kind | input | 1 | 1 = unconditional jump |
| up_taken | input | 1 | Resolved outcome |
| up_tgt | input | PC_W | Resolved target |
| rs_vld | output | 1 | Classification valid (one cycle after update) |
| rs_cls | output | 2 | 0 correct, 1 target miss, 2 mispredict |

## Verification
The bench builds the block with HIST_W=4, SETS=4, WAYS=4 and PC_W=16. The counter table then has 16 entries and each set has 4 ways. Branch addresses drawn from eight tags over four sets reach every counter and every set, repeatedly fill sets past capacity, and give many history aliases across the two threads. A small arithmetic model of the tables predicts every lookup and every classification for directed sequences and for a long pseudo-random stream. This covers bias marking and unmarking, counter saturation, pseudo-LRU eviction order and same-cycle read-before-write.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CLS_OK   = 2'd0,
    CLS_TGT  = 2'd1,
    CLS_MISP = 2'd2
  } bp_cls_e;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;
endpackage

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int THREADS = 2,
  parameter int HIST_W  = 12,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sh_en,
  input  logic [TID_W-1:0]  sh_tid,
  input  logic              sh_bit,
  input  logic [TID_W-1:0]  rd_tid_a,
  input  logic [TID_W-1:0]  rd_tid_b,
  output logic [HIST_W-1:0] hist_a,
  output logic [HIST_W-1:0] hist_b
);
  logic [HIST_W-1:0] hist_q [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[t] <= '0;
      end else if (sh_en && (sh_tid == TID_W'(t))) begin
        hist_q[t] <= {hist_q[t][HIST_W-2:0], sh_bit};
      end
    end
  end

  assign hist_a = hist_q[rd_tid_a];
  assign hist_b = hist_q[rd_tid_b];
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int IDX_W  = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic [1:0]       ctr_a,
  output logic [1:0]       ctr_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;

  logic [1:0] ctr_q [DEPTH];
  logic [1:0] cur;
  logic [1:0] nxt;

  assign cur = ctr_q[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_taken && (cur != 2'b11)) nxt = cur + 2'd1;
    else if (!wr_taken && (cur != 2'b00)) nxt = cur - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= nxt;
    end
  end

  assign ctr_a = ctr_q[idx_a];
  assign ctr_b = ctr_q[idx_b];
endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int PC_W  = 32,
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - 2 - SET_W,
  localparam int ENT   = SETS * WAYS,
  localparam int ENT_W = SET_W + WAY_W,
  localparam int TR_W  = WAYS - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] a_pc,
  output logic            a_hit,
  output logic [PC_W-1:0] a_tgt,
  output logic            a_st,
  output logic            a_sn,
  input  logic [PC_W-1:0] b_pc,
  output logic            b_hit,
  output logic            b_st,
  output logic            b_sn,
  input  logic            wr_en,
  input  logic            wr_taken,
  input  logic [PC_W-1:0] wr_tgt
);
  logic [ENT-1:0]   vld_q;
  logic [ENT-1:0]   st_q;
  logic [ENT-1:0]   sn_q;
  logic [TAG_W-1:0] tag_q [ENT];
  logic [PC_W-1:0]  tgt_q [ENT];
  logic [TR_W-1:0]  plru_q [SETS];

  function automatic logic [ENT_W-1:0] ent(input logic [SET_W-1:0] s,
                                          input logic [WAY_W-1:0] w);
    return {s, w};
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(input logic [TR_W-1:0] t);
    logic [WAY_W-1:0] w;
    int node;
    logic b;
    w = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      b = t[node];
      w = (w << 1) | WAY_W'(b);
      node = 2 * node + 1 + int'(b);
    end
    return w;
  endfunction

  function automatic logic [TR_W-1:0] plru_touch(input logic [TR_W-1:0] t,
                                                input logic [WAY_W-1:0] w);
    logic [TR_W-1:0] r;
    int node;
    logic b;
    r = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      b = w[WAY_W-1-l];
      r[node] = ~b;
      node = 2 * node + 1 + int'(b);
    end
    return r;
  endfunction

  logic [SET_W-1:0] a_set, b_set;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [WAY_W-1:0] a_way, b_way, b_free, b_vict, b_alloc;
  logic             b_has_free;

  assign a_set = a_pc[2 +: SET_W];
  assign a_tag = a_pc[PC_W-1 -: TAG_W];
  assign b_set = b_pc[2 +: SET_W];
  assign b_tag = b_pc[PC_W-1 -: TAG_W];

  always_comb begin
    a_hit = 1'b0;
    a_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[ent(a_set, WAY_W'(w))] && (tag_q[ent(a_set, WAY_W'(w))] == a_tag)) begin
        a_hit = 1'b1;
        a_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    b_hit = 1'b0;
    b_way = '0;
    b_has_free = 1'b0;
    b_free = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[ent(b_set, WAY_W'(w))] && (tag_q[ent(b_set, WAY_W'(w))] == b_tag)) begin
        b_hit = 1'b1;
        b_way = WAY_W'(w);
      end
      if (!vld_q[ent(b_set, WAY_W'(w))]) begin
        b_has_free = 1'b1;
        b_free = WAY_W'(w);
      end
    end
  end

  assign b_vict  = plru_victim(plru_q[b_set]);
  assign b_alloc = b_has_free ? b_free : b_vict;

  assign a_tgt = tgt_q[ent(a_set, a_way)];
  assign a_st  = a_hit & st_q[ent(a_set, a_way)];
  assign a_sn  = a_hit & sn_q[ent(a_set, a_way)];
  assign b_st  = b_hit & st_q[ent(b_set, b_way)];
  assign b_sn  = b_hit & sn_q[ent(b_set, b_way)];

  // control bits: reset, per-entry state and replacement trees
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      st_q  <= '0;
      sn_q  <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else if (wr_en) begin
      if (b_hit) begin
        if (wr_taken) st_q[ent(b_set, b_way)] <= 1'b1;
        else          sn_q[ent(b_set, b_way)] <= 1'b1;
        plru_q[b_set] <= plru_touch(plru_q[b_set], b_way);
      end else if (wr_taken) begin
        vld_q[ent(b_set, b_alloc)] <= 1'b1;
        st_q[ent(b_set, b_alloc)]  <= 1'b1;
        sn_q[ent(b_set, b_alloc)]  <= 1'b0;
        plru_q[b_set] <= plru_touch(plru_q[b_set], b_alloc);
      end
    end
  end

  // tag and target arrays: no reset so they map to memory
  always_ff @(posedge clk) begin
    if (wr_en && wr_taken) begin
      if (b_hit) begin
        tgt_q[ent(b_set, b_way)] <= wr_tgt;
      end else begin
        tag_q[ent(b_set, b_alloc)] <= b_tag;
        tgt_q[ent(b_set, b_alloc)] <= wr_tgt;
      end
    end
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 12,
  parameter int SETS    = 32,
  parameter int WAYS    = 4,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_kind,
  output logic             lk_taken,
  output logic             lk_tgt_vld,
  output logic [PC_W-1:0]  lk_tgt,
  output logic [1:0]       lk_pen,
  input  logic             up_vld,
  input  logic [TID_W-1:0] up_tid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_kind,
  input  logic             up_taken,
  input  logic [PC_W-1:0]  up_tgt,
  output logic             rs_vld,
  output logic [1:0]       rs_cls
);
  import bp_pkg::*;

  logic [HIST_W-1:0] hist_a, hist_b;
  logic [HIST_W-1:0] idx_a, idx_b;
  logic [1:0]        ctr_a, ctr_b;
  logic              a_hit, a_st, a_sn;
  logic              b_hit, b_st, b_sn;
  logic [PC_W-1:0]   a_tgt;
  logic              up_dir, eff_taken, cond_up, pht_wr;
  bp_cls_e           cls_d;

  function automatic logic pred_dir(input logic uncond, input logic hit,
                                    input logic st, input logic sn,
                                    input logic [1:0] ctr);
    if (uncond)              return 1'b1;
    if (hit && (st ^ sn))    return st;
    return ctr[1];
  endfunction

  assign eff_taken = up_kind | up_taken;
  assign cond_up   = up_vld & ~up_kind;
  assign idx_a     = hist_a ^ lk_pc[HIST_W+1:2];
  assign idx_b     = hist_b ^ up_pc[HIST_W+1:2];
  assign pht_wr    = cond_up & b_hit & b_st & b_sn;

  bp_hist #(.THREADS(THREADS), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst),
    .sh_en(cond_up), .sh_tid(up_tid), .sh_bit(up_taken),
    .rd_tid_a(lk_tid), .rd_tid_b(up_tid),
    .hist_a(hist_a), .hist_b(hist_b)
  );

  bp_pht #(.IDX_W(HIST_W)) u_pht (
    .clk(clk), .rst(rst),
    .idx_a(idx_a), .idx_b(idx_b), .ctr_a(ctr_a), .ctr_b(ctr_b),
    .wr_en(pht_wr), .wr_idx(idx_b), .wr_taken(up_taken)
  );

  bp_btb #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS)) u_btb (
    .clk(clk), .rst(rst),
    .a_pc(lk_pc), .a_hit(a_hit), .a_tgt(a_tgt), .a_st(a_st), .a_sn(a_sn),
    .b_pc(up_pc), .b_hit(b_hit), .b_st(b_st), .b_sn(b_sn),
    .wr_en(up_vld), .wr_taken(eff_taken), .wr_tgt(up_tgt)
  );

  assign lk_taken   = pred_dir(lk_kind, a_hit, a_st, a_sn, ctr_a);
  assign lk_tgt_vld = a_hit;
  assign lk_tgt     = a_tgt;
  assign lk_pen     = (lk_taken && !a_hit) ? CLS_TGT : CLS_OK;

  assign up_dir = pred_dir(up_kind, b_hit, b_st, b_sn, ctr_b);

  always_comb begin
    if (up_dir != eff_taken)        cls_d = CLS_MISP;
    else if (eff_taken && !b_hit)   cls_d = CLS_TGT;
    else                            cls_d = CLS_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_vld <= 1'b0;
      rs_cls <= CLS_OK;
    end else begin
      rs_vld <= up_vld;
      rs_cls <= up_vld ? cls_d : CLS_OK;
    end
  end
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_kind,
  input logic            lk_taken,
  input logic            lk_tgt_vld,
  input logic [1:0]      lk_pen,
  input logic            up_vld,
  input logic            up_kind,
  input logic            rs_vld,
  input logic [1:0]      rs_cls,
  input logic [PC_W-1:0] lk_tgt
);
  // R4: jumps always predicted taken
  a_r4_jump_taken: assert property (@(posedge clk) disable iff (rst)
    lk_kind |-> lk_taken);

  // R9: penalty class from direction and target availability
  a_r9_pen_tgt: assert property (@(posedge clk) disable iff (rst)
    (lk_taken && !lk_tgt_vld) |-> (lk_pen == 2'd1));
  a_r9_pen_none: assert property (@(posedge clk) disable iff (rst)
    (!lk_taken || lk_tgt_vld) |-> (lk_pen == 2'd0));

  // R10: classification timing and range
  a_r10_rs_follows: assert property (@(posedge clk) disable iff (rst)
    up_vld |=> rs_vld);
  a_r10_rs_idle: assert property (@(posedge clk) disable iff (rst)
    !up_vld |=> !rs_vld);
  a_r10_jump_no_misp: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_kind) |=> (rs_cls != 2'd2));
  a_r10_cls_range: assert property (@(posedge clk) disable iff (rst)
    rs_vld |-> (rs_cls != 2'd3));

  // R7: a reported target is word aligned only if it was written so; target bus must not be unknown on a hit
  a_r7_tgt_known: assert property (@(posedge clk) disable iff (rst)
    lk_tgt_vld |-> !$isunknown(lk_tgt));
endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .lk_kind(lk_kind), .lk_taken(lk_taken),
  .lk_tgt_vld(lk_tgt_vld), .lk_pen(lk_pen), .up_vld(up_vld),
  .up_kind(up_kind), .rs_vld(rs_vld), .rs_cls(rs_cls), .lk_tgt(lk_tgt)
);

// File: tb/tb_bp_predictor.sv
module tb_bp_predictor;
  localparam int PC_W = 16, HIST_W = 4, SETS = 4, WAYS = 4;
  localparam int NPHT = 1 << HIST_W;

  logic clk = 0, rst = 1;
  logic lk_tid = 0, lk_kind = 0, up_vld = 0, up_tid = 0, up_kind = 0, up_taken = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0, up_tgt = '0, lk_tgt;
  logic lk_taken, lk_tgt_vld, rs_vld;
  logic [1:0] lk_pen, rs_cls;

  always #5 clk = ~clk;

  bp_predictor #(.PC_W(PC_W), .HIST_W(HIST_W), .SETS(SETS), .WAYS(WAYS), .THREADS(2)) dut (
    .clk(clk), .rst(rst), .lk_tid(lk_tid), .lk_pc(lk_pc), .lk_kind(lk_kind),
    .lk_taken(lk_taken), .lk_tgt_vld(lk_tgt_vld), .lk_tgt(lk_tgt), .lk_pen(lk_pen),
    .up_vld(up_vld), .up_tid(up_tid), .up_pc(up_pc), .up_kind(up_kind),
    .up_taken(up_taken), .up_tgt(up_tgt), .rs_vld(rs_vld), .rs_cls(rs_cls));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model of the tables
  logic [HIST_W-1:0] m_hist [2];
  logic [1:0]  m_ctr [NPHT];
  logic        m_v [SETS][WAYS];
  logic        m_st [SETS][WAYS];
  logic        m_sn [SETS][WAYS];
  logic [11:0] m_tag [SETS][WAYS];
  logic [15:0] m_tgt [SETS][WAYS];
  logic [2:0]  m_lru [SETS];
  logic        exp_rs_vld = 0;
  logic [1:0]  exp_rs_cls = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_hist[0] = '0; m_hist[1] = '0;
    for (int i = 0; i < NPHT; i++) m_ctr[i] = 2'b01;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = '0;
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_st[s][w] = 0; m_sn[s][w] = 0;
      end
    end
  endtask

  task automatic m_find(input logic [15:0] pc, output bit hit, output int way);
    int s = int'(pc[3:2]);
    hit = 0; way = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_tag[s][w] == pc[15:4]) begin hit = 1; way = w; end
  endtask

  function automatic bit m_dir(input logic tid, input logic [15:0] pc, input logic kind,
                               input bit hit, input int way);
    int s = int'(pc[3:2]);
    if (kind) return 1;
    if (hit && (m_st[s][way] != m_sn[s][way])) return m_st[s][way];
    return m_ctr[m_hist[tid] ^ pc[5:2]][1];
  endfunction

  task automatic m_touch(input int s, input int w);
    m_lru[s][0] = ~w[1];
    if (w < 2) m_lru[s][1] = ~w[0]; else m_lru[s][2] = ~w[0];
  endtask

  task automatic step(input logic ltid, input logic [15:0] lpc, input logic lkind,
                      input logic uv, input logic utid, input logic [15:0] upc,
                      input logic ukind, input logic utk, input logic [15:0] utgt,
                      input string tag);
    bit hit; int way; bit dir; int s;
    int cls;
    @(negedge clk);
    lk_tid = ltid; lk_pc = lpc; lk_kind = lkind;
    up_vld = uv; up_tid = utid; up_pc = upc; up_kind = ukind; up_taken = utk; up_tgt = utgt;
    #1;
    m_find(lpc, hit, way);
    dir = m_dir(ltid, lpc, lkind, hit, way);
    chk({tag, " R2 R5 lk_taken"}, "", int'(lk_taken), int'(dir));
    chk({tag, " R7 lk_tgt_vld"}, "", int'(lk_tgt_vld), int'(hit));
    if (hit) chk({tag, " R7 lk_tgt"}, "", int'(lk_tgt), int'(m_tgt[lpc[3:2]][way]));
    chk({tag, " R9 lk_pen"}, "", int'(lk_pen), (dir && !hit) ? 1 : 0);
    chk({tag, " R10 rs_vld"}, "", int'(rs_vld), int'(exp_rs_vld));
    if (exp_rs_vld) chk({tag, " R10 rs_cls"}, "", int'(rs_cls), int'(exp_rs_cls));
    exp_rs_vld = uv;
    if (uv) begin
      bit et = ukind | utk;
      m_find(upc, hit, way);
      dir = m_dir(utid, upc, ukind, hit, way);
      s = int'(upc[3:2]);
      cls = (dir != et) ? 2 : ((et && !hit) ? 1 : 0);
      exp_rs_cls = 2'(cls);
      if (!ukind) begin
        if (hit && m_st[s][way] && m_sn[s][way]) begin
          int ix = int'(m_hist[utid] ^ upc[5:2]);
          if (utk && m_ctr[ix] != 3) m_ctr[ix] = m_ctr[ix] + 1;
          if (!utk && m_ctr[ix] != 0) m_ctr[ix] = m_ctr[ix] - 1;
        end
        m_hist[utid] = {m_hist[utid][HIST_W-2:0], utk};
      end
      if (hit) begin
        if (et) begin m_st[s][way] = 1; m_tgt[s][way] = utgt; end
        else m_sn[s][way] = 1;
        m_touch(s, way);
      end else if (et) begin
        int aw = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!m_v[s][w]) aw = w;
        if (aw < 0) aw = m_lru[s][0] ? (2 + int'(m_lru[s][2])) : int'(m_lru[s][1]);
        m_v[s][aw] = 1; m_st[s][aw] = 1; m_sn[s][aw] = 0;
        m_tag[s][aw] = upc[15:4]; m_tgt[s][aw] = utgt;
        m_touch(s, aw);
      end
    end
  endtask

  task automatic idle(input logic tid, input logic [15:0] pc, input logic kind, input string tag);
    step(tid, pc, kind, 0, 0, 16'h0, 0, 0, 16'h0, tag);
  endtask

  function automatic logic [15:0] mkpc(input int tg, input int st);
    return {9'd0, 3'(tg), 2'(st), 2'b00};
  endfunction

  function automatic logic [31:0] lfsr(input logic [31:0] r);
    return r[0] ? ((r >> 1) ^ 32'h80200003) : (r >> 1);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r = 32'h1ACE_5EED;
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state for every set and tag
    for (int t = 0; t < 8; t++) idle(t[0], mkpc(t, t % 4), 0, "R1");

    // R4: jump installs target, no history or counter change
    step(0, mkpc(1, 0), 1, 1, 0, mkpc(1, 0), 1, 0, 16'h0400, "R4");
    step(0, mkpc(1, 0), 1, 0, 0, 16'h0, 0, 0, 16'h0, "R4");
    idle(0, mkpc(0, 1), 0, "R4");

    // R5 R6: conditional branch, bias then both marks then training
    for (int k = 0; k < 3; k++)
      step(0, mkpc(2, 1), 0, 1, 0, mkpc(2, 1), 0, 1, 16'h0800, "R5");
    for (int k = 0; k < 8; k++)
      step(0, mkpc(2, 1), 0, 1, 0, mkpc(2, 1), 0, k[0], 16'h0810, "R6");
    for (int k = 0; k < 6; k++)
      step(1, mkpc(2, 1), 0, 1, 1, mkpc(2, 1), 0, 1, 16'h0820, "R6");

    // R3 R12: threads interleaved on shared entries, separate histories
    for (int k = 0; k < 12; k++)
      step(k[0], mkpc(k % 8, 2), 0, 1, ~k[0], mkpc(k % 8, 2), 0, k[1], 16'h1000, "R3");
    idle(1, mkpc(3, 2), 0, "R12");

    // R8: overfill one set and walk the pseudo-LRU order
    for (int k = 0; k < 14; k++)
      step(0, mkpc((k * 3) % 8, 3), 0, 1, 0, mkpc((k * 3) % 8, 3), 1, 1, 16'(16'h2000 + k * 4), "R8");
    for (int t = 0; t < 8; t++) idle(0, mkpc(t, 3), 0, "R8");

    // R11: same-cycle lookup sees old state, next cycle sees new
    step(0, mkpc(6, 0), 0, 1, 0, mkpc(6, 0), 0, 1, 16'h3000, "R11");
    idle(0, mkpc(6, 0), 0, "R11");

    // R2 R10: pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      r = lfsr(r); a = r;
      r = lfsr(r); b = r;
      step(b[0], mkpc(int'(b[3:1]), int'(b[5:4])), (b[8:6] == 0),
           a[12] | a[13], a[10], mkpc(int'(a[2:0]), int'(a[4:3])), (a[7:5] == 0),
           (a[7:5] == 0) | a[8] | a[9], {a[27:14], 2'b00}, "R2");
    end
    idle(0, 16'h0, 0, "R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule